// File: doc/BRIEF.md
# Mux-Tree Magnitude Comparator

This block compares two unsigned operands of equal, parameterised width and raises `swap` when operand B is strictly larger than operand A. An alignment or leading-one prediction stage uses this flag to put its two mantissas in order before it works on them. A second flag, `equal`, reports that the operands are identical.

The block has no subtractor and no carry chain. Each bit position produces a difference flag (A xor B) and carries B's bit as its data. A tree of priority multiplexers merges the positions pairwise, or four at a time, toward the most significant end. At every node the most significant child that differs wins. The root therefore holds B's bit at the highest differing position. That bit, ANDed with the root difference flag, is the swap result.

Parameters set the operand width, the tree radix (2 or 4) and an optional output register. With a width that is not a power of the radix, the operands are zero-extended at the top inside the block.

Top module: `mag_cmp_tree`

## Requirements
- R1: `swap` is 1 exactly when `op_b` is greater than `op_a`, both read as unsigned binary numbers.
- R2: `equal` is 1 exactly when `op_a` and `op_b` are bit-for-bit identical.
- R3: Only the most significant differing bit position decides `swap`, which then equals `op_b` at that position. For example, with A = 1001 and B = 1100, `swap` is 1, and lower bits have no effect.
- R4: Identical operands, including all zeros and all ones, give `swap` = 0.
- R5: `swap` and `equal` are never 1 at the same time.
- R6: When the operands differ only in bit 0, `swap` equals `op_b[0]`.
- R7: RADIX = 2 and RADIX = 4 give identical results. A WIDTH that is not a power of RADIX (for example 13 with RADIX = 4) is handled by zero-extending at the top, and this does not change any result.
- R8: With REG_OUT = 1, both outputs show the result for the inputs present at the previous rising clock edge, and an active-low `rst_n` forces both to 0. With REG_OUT = 0, both outputs follow the inputs combinationally.
- R9: Bit WIDTH-1 is the most significant bit. A difference only in that bit sets `swap` to `op_b[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | WIDTH | Operand A, unsigned |
| op_b | input | WIDTH | Operand B, unsigned |
| swap | output | 1 | 1 when B > A |
| equal | output | 1 | 1 when A == B |

## Verification
Random 64-bit operands almost always differ in their top few bits, so the deep paths of the tree, where a long equal prefix hands the decision to a low-order node, are almost never reached. The stimulus therefore builds many of its pairs from a random A and a B equal to A with one chosen bit flipped, or with only the bits below a random split point re-drawn. This forces the winning difference down to any level of the tree, including bit 0 alone and the top bit alone. A 13-bit radix-4 instance runs on the low bits of the same vectors, so the padded positions and the 4:1 fall-through are exercised by the same patterns.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  // Integer power, used to size each level of the tree.
  function automatic int pow_i(input int base, input int ex);
    int r;
    r = 1;
    for (int k = 0; k < ex; k++) r = r * base;
    return r;
  endfunction

  // Number of mux levels needed so that radix**levels covers the width.
  function automatic int levels_for(input int width, input int radix);
    int span;
    int lv;
    span = 1;
    lv   = 0;
    while (span < width) begin
      span = span * radix;
      lv   = lv + 1;
    end
    if (lv == 0) lv = 1;
    return lv;
  endfunction

  // Priority pick over up to four children: highest index with its
  // difference flag set wins; with no flag set the lowest child passes.
  function automatic logic pick_hi(input logic [3:0] dat, input logic [3:0] dif);
    logic r;
    if (dif[3])      r = dat[3];
    else if (dif[2]) r = dat[2];
    else if (dif[1]) r = dat[1];
    else             r = dat[0];
    return r;
  endfunction

endpackage

// File: rtl/mtc_leaf.sv
module mtc_leaf #(
  parameter int WIDTH = 64,
  parameter int PW    = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [PW-1:0]    p,
  output logic [PW-1:0]    v
);
  logic [PW-1:0] a_x;
  logic [PW-1:0] b_x;

  // Zero-extend at the top; padded positions never differ.
  if (PW > WIDTH) begin : g_pad
    assign a_x = {{(PW-WIDTH){1'b0}}, a};
    assign b_x = {{(PW-WIDTH){1'b0}}, b};
  end else begin : g_nopad
    assign a_x = a;
    assign b_x = b;
  end

  assign p = b_x;
  assign v = a_x ^ b_x;
endmodule

// File: rtl/mtc_node.sv
module mtc_node import mtc_pkg::*; #(
  parameter int RADIX = 2
) (
  input  logic [RADIX-1:0] kd,
  input  logic [RADIX-1:0] kv,
  output logic             pd,
  output logic             pv
);
  logic [3:0] d4;
  logic [3:0] v4;

  if (RADIX == 4) begin : g_r4
    assign d4 = kd;
    assign v4 = kv;
  end else begin : g_r2
    assign d4 = {2'b00, kd};
    assign v4 = {2'b00, kv};
  end

  assign pd = pick_hi(d4, v4);
  assign pv = |kv;

  always_comb begin
    // R3: a differing top child always decides the node.
    if (kv[RADIX-1]) begin
      p_top_child_wins_r3: assert (pd == kd[RADIX-1]);
    end
    // R7: with no difference below, the lowest child passes through.
    if (!pv) begin
      p_fallthrough_low_r7: assert (pd == kd[0]);
    end
  end
endmodule

// File: rtl/mtc_tree.sv
module mtc_tree import mtc_pkg::*; #(
  parameter int RADIX  = 2,
  parameter int LEVELS = 6,
  parameter int PW     = 64
) (
  input  logic [PW-1:0] leaf_d,
  input  logic [PW-1:0] leaf_v,
  output logic          root_d,
  output logic          root_v
);
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = PW / pow_i(RADIX, l);
    logic [CNT-1:0] d;
    logic [CNT-1:0] v;
    if (l == 0) begin : g_base
      assign d = leaf_d;
      assign v = leaf_v;
    end else begin : g_mux
      for (genvar i = 0; i < CNT; i++) begin : g_node
        mtc_node #(.RADIX(RADIX)) u_node (
          .kd (g_lvl[l-1].d[i*RADIX +: RADIX]),
          .kv (g_lvl[l-1].v[i*RADIX +: RADIX]),
          .pd (d[i]),
          .pv (v[i])
        );
      end
    end
  end

  assign root_d = g_lvl[LEVELS].d[0];
  assign root_v = g_lvl[LEVELS].v[0];
endmodule

// File: rtl/mtc_out.sv
module mtc_out #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gt_c,
  input  logic eq_c,
  output logic swap,
  output logic equal
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        swap  <= 1'b0;
        equal <= 1'b0;
      end else begin
        swap  <= gt_c;
        equal <= eq_c;
      end
    end

    p_reg_gt_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gt_c |=> swap);
    p_reg_le_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gt_c |=> !swap);
  end else begin : g_comb
    assign swap  = gt_c;
    assign equal = eq_c;
  end

  p_out_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap && equal));
endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree import mtc_pkg::*; #(
  parameter int WIDTH   = 64,
  parameter int RADIX   = 2,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             swap,
  output logic             equal
);
  localparam int LEVELS = levels_for(WIDTH, RADIX);
  localparam int PW     = pow_i(RADIX, LEVELS);

  logic [PW-1:0] leaf_d;
  logic [PW-1:0] leaf_v;
  logic          root_d;
  logic          root_v;
  logic          cmp_gt;
  logic          cmp_eq;

  mtc_leaf #(.WIDTH(WIDTH), .PW(PW)) u_leaf (
    .a (op_a),
    .b (op_b),
    .p (leaf_d),
    .v (leaf_v)
  );

  mtc_tree #(.RADIX(RADIX), .LEVELS(LEVELS), .PW(PW)) u_tree (
    .leaf_d (leaf_d),
    .leaf_v (leaf_v),
    .root_d (root_d),
    .root_v (root_v)
  );

  // Final gate: the chosen B bit only counts if some position differs.
  assign cmp_gt = root_d & root_v;
  assign cmp_eq = ~root_v;

  mtc_out #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .gt_c  (cmp_gt),
    .eq_c  (cmp_eq),
    .swap  (swap),
    .equal (equal)
  );

  p_same_no_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == op_b) |-> (!cmp_gt && cmp_eq));
  p_cmp_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_gt && cmp_eq));
  p_msb_decides_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[WIDTH-1] != op_b[WIDTH-1]) |-> (cmp_gt == op_b[WIDTH-1]));
  p_lsb_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a ^ op_b) == WIDTH'(1)) |-> (cmp_gt == op_b[0]));
  p_diff_not_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != op_b) |-> !cmp_eq);
endmodule

// File: tb/mag_cmp_tree_tb.sv
`timescale 1ns/1ps
module mag_cmp_tree_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a64 = '0;
  logic [63:0] b64 = '0;
  logic [12:0] a13;
  logic [12:0] b13;
  logic        swap64, equal64, swap13, equal13;
  logic        run = 1'b0;
  logic        done = 1'b0;
  string       cur_tag = "R1";
  int          n_tests = 0;
  int          n_fail = 0;

  typedef struct {
    logic  gt;
    logic  eq;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #2.5 clk = ~clk;

  assign a13 = a64[12:0];
  assign b13 = b64[12:0];

  mag_cmp_tree #(.WIDTH(64), .RADIX(2), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(a64), .op_b(b64),
    .swap(swap64), .equal(equal64));

  mag_cmp_tree #(.WIDTH(13), .RADIX(4), .REG_OUT(1'b0)) u_dut_r4 (
    .clk(clk), .rst_n(rst_n), .op_a(a13), .op_b(b13),
    .swap(swap13), .equal(equal13));

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got=%0b expected=%0b (a=%h b=%h)", req, what, got, exp, a64, b64);
    end
  endtask

  // Reference: plain unsigned compare, one-cycle queue for the registered instance.
  always @(posedge clk) begin
    if (rst_n && run) q.push_back('{b64 > a64, a64 == b64, cur_tag});
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        check(swap64, e.gt, e.tag, "R8 registered swap, 64b radix-2");
        check(equal64, e.eq, e.tag, "R8 registered equal, 64b radix-2");
        check(swap64 & equal64, 1'b0, "R5", "exclusive flags 64b");
      end
      check(swap13, b13 > a13, cur_tag, "R7 swap, 13b radix-4 padded");
      check(equal13, a13 == b13, cur_tag, "R7 equal, 13b radix-4 padded");
      check(swap13 & equal13, 1'b0, "R5", "exclusive flags 13b");
    end
  end

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input string tag);
    @(posedge clk);
    #1;
    a64 = a;
    b64 = b;
    cur_tag = tag;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra;
    logic [63:0] rb;
    logic [63:0] msk;
    repeat (3) @(negedge clk);
    // R8: during reset the registered outputs are 0 even for equal inputs.
    check(swap64, 1'b0, "R8", "reset swap");
    check(equal64, 1'b0, "R8", "reset equal");
    rst_n = 1'b1;
    run = 1'b1;

    apply(64'h9, 64'hC, "R3");
    apply(64'hC, 64'h9, "R3");
    apply(64'h0, 64'h0, "R4");
    apply('1, '1, "R4");
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R2");
    apply(64'h0, 64'h1, "R6");
    apply(64'h1, 64'h0, "R6");
    apply(64'hFFFF_FFFF_FFFF_FFFE, '1, "R6");
    apply(64'h0, 64'h8000_0000_0000_0000, "R9");
    apply('1, 64'h7FFF_FFFF_FFFF_FFFF, "R9");
    apply(64'h0, 64'h1000, "R7");
    apply(64'h1FFF, 64'h0FFF, "R7");

    for (int k = 0; k < 64; k++) begin
      ra = rnd64();
      apply(ra, ra ^ (64'h1 << k), "R3");
      apply(ra ^ (64'h1 << k), ra, "R3");
    end

    for (int n = 0; n < 1500; n++) begin
      ra = rnd64();
      rb = rnd64();
      case (n % 4)
        0: apply(ra, rb, "R1");
        1: begin
          msk = (64'h1 << ($urandom() % 64)) - 64'h1;
          apply(ra, (ra & ~msk) | (rb & msk), "R1");
        end
        2: apply(ra, ra, "R2");
        default: begin
          msk = (64'h1 << ($urandom() % 13)) - 64'h1;
          apply(ra, (ra & ~msk) | (rb & msk), "R7");
        end
      endcase
    end

    apply(64'h0, 64'h0, "R4");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule